// File: doc/BRIEF.md
# USB Device Frame Tracker with Early Frame-End Alert

This block sits on the device side of a full-speed USB controller, after token decoding and CRC checking. A one-cycle strobe marks each valid start-of-frame token that arrives, and the token's frame number is presented alongside it. On every strobe the block does four things:

- It sets a sticky start-of-frame interrupt flag.
- It captures the frame number.
- It starts a fixed-width pulse. Two separate enables route this pulse to an external pin and to an internal timer trigger.
- It restarts an elapsed-time counter for the new frame.

When the elapsed time reaches a selectable fraction of the nominal frame length, a second sticky flag is raised. Software can use this alert to check, before the next frame begins, whether its isochronous transfers for the current frame have finished. If start-of-frame tokens stop arriving, the counter holds at the nominal frame length and stays silent.

Top module: `sof_frame_tracker`

## Requirements
- R1: A high `sof_stb` sampled on a clock edge makes `sof_irq` high from the next cycle. The flag stays high until `clr_sof_irq` is sampled high in a cycle without a strobe. A strobe and a clear in the same cycle leave the flag set.
- R2: On every strobe, `frame_num` takes the value of `sof_frame` from that cycle, in the next cycle, and holds it until the next strobe. This includes the maximum value 2047.
- R3: Each strobe produces an internal pulse that is high for exactly PULSE_W cycles (default 12), starting the cycle after the strobe. A strobe that arrives while a pulse is running restarts the full width.
- R4: `sof_pin` carries the pulse only while `pin_en` is high. `sof_trig` carries it only while `trig_en` is high. The two enables act independently and are applied in the same cycle, without a register.
- R5: `eopf_sel` selects the alert threshold as a fraction of FRAME_CLKS: 00 = 80%, 01 = 85%, 10 = 90%, 11 = 95%. For the default 12000-clock frame these are 9600, 10200, 10800 and 11400 clocks. The elapsed count is 0 in the cycle after a strobe and rises by one per cycle. `eopf_irq` goes high in the cycle after the count equals the threshold.
- R6: The elapsed count stops at FRAME_CLKS. The alert fires at most once per frame, and never again until another strobe has arrived.
- R7: `eopf_irq` is sticky. It is cleared by `clr_eopf_irq` in a cycle in which the threshold is not being reached; if the threshold is reached in that same cycle, the set wins.
- R8: `eopf_sel` is sampled only on a strobe. A change to it in the middle of a frame has no effect until the next strobe.
- R9: After reset, both flags, `frame_num` and both pulse outputs are 0. No alert fires until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_stb | input | 1 | One-cycle marker of a received start-of-frame token |
| sof_frame | input | FN_W | Frame number carried by that token |
| pin_en | input | 1 | Routes the pulse to the external pin |
| trig_en | input | 1 | Routes the pulse to the timer trigger |
| eopf_sel | input | 2 | Alert threshold selection |
| clr_sof_irq | input | 1 | Write-1 clear of the start-of-frame flag |
| clr_eopf_irq | input | 1 | Write-1 clear of the frame-end alert flag |
| sof_irq | output | 1 | Sticky start-of-frame flag |
| eopf_irq | output | 1 | Sticky frame-end alert flag |
| frame_num | output | FN_W | Latched frame number |
| sof_pin | output | 1 | Gated pulse to the external pin |
| sof_trig | output | 1 | Gated pulse to the timer trigger |

## Verification
The in-module assertions check on every cycle the relations that hold regardless of history. A strobe sets the start-of-frame flag and starts the pulse. The frame number follows the strobe. A clear with no competing set drops a flag. The elapsed count never passes the frame length.

Only the bench scenarios can show the properties that depend on history:
- the exact pulse width, and its restart on a second strobe;
- the threshold cycle for each of the four selections;
- the single alert per frame and the silence once the count saturates;
- the deferral of a mid-frame change to the selection.

The bench checks these by comparing every output on every cycle against a behavioural model.

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker #(
  parameter int FRAME_CLKS = 12000,
  parameter int PULSE_W    = 12,
  parameter int FN_W       = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_stb,
  input  logic [FN_W-1:0] sof_frame,
  input  logic            pin_en,
  input  logic            trig_en,
  input  logic [1:0]      eopf_sel,
  input  logic            clr_sof_irq,
  input  logic            clr_eopf_irq,
  output logic            sof_irq,
  output logic            eopf_irq,
  output logic [FN_W-1:0] frame_num,
  output logic            sof_pin,
  output logic            sof_trig
);
  localparam int CW = $clog2(FRAME_CLKS + 1);
  localparam int PW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] FRAME_END = CW'(FRAME_CLKS);
  localparam logic [CW-1:0] THR80 = CW'(FRAME_CLKS * 80 / 100);
  localparam logic [CW-1:0] THR85 = CW'(FRAME_CLKS * 85 / 100);
  localparam logic [CW-1:0] THR90 = CW'(FRAME_CLKS * 90 / 100);
  localparam logic [CW-1:0] THR95 = CW'(FRAME_CLKS * 95 / 100);

  logic [CW-1:0] elapsed;
  logic [PW-1:0] pulse_cnt;
  logic [1:0]    sel_q;
  logic [CW-1:0] thr;
  logic          pulse_on;
  logic          eopf_hit;

  always_comb begin
    case (sel_q)
      2'd0:    thr = THR80;
      2'd1:    thr = THR85;
      2'd2:    thr = THR90;
      default: thr = THR95;
    endcase
  end

  assign pulse_on = (pulse_cnt != '0);
  assign eopf_hit = !sof_stb && (elapsed == thr);
  assign sof_pin  = pulse_on && pin_en;
  assign sof_trig = pulse_on && trig_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed   <= FRAME_END;
      pulse_cnt <= '0;
      sel_q     <= 2'd0;
      frame_num <= '0;
      sof_irq   <= 1'b0;
      eopf_irq  <= 1'b0;
    end else begin
      if (sof_stb) begin
        elapsed   <= '0;
        pulse_cnt <= PW'(PULSE_W);
        sel_q     <= eopf_sel;
        frame_num <= sof_frame;
        sof_irq   <= 1'b1;
      end else begin
        if (elapsed != FRAME_END) elapsed <= elapsed + 1'b1;
        if (pulse_on) pulse_cnt <= pulse_cnt - 1'b1;
        if (clr_sof_irq) sof_irq <= 1'b0;
      end
      if (eopf_hit) eopf_irq <= 1'b1;
      else if (clr_eopf_irq) eopf_irq <= 1'b0;
    end
  end

  p_sof_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> sof_irq);
  p_sof_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sof_irq && !sof_stb) |=> !sof_irq);
  p_fn_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> (frame_num == $past(sof_frame)));
  p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> pulse_on);
  p_elapsed_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed <= FRAME_END);
  p_eopf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eopf_irq && !eopf_hit) |=> !eopf_irq);
endmodule

// File: tb/sof_frame_tracker_tb.sv
module sof_frame_tracker_tb;
  localparam int PERIOD = 10;
  localparam int FRAME  = 200;
  localparam int PW     = 12;

  logic clk = 0, rst_n = 0;
  logic sof_stb = 0, pin_en = 0, trig_en = 0, clr_sof_irq = 0, clr_eopf_irq = 0;
  logic [10:0] sof_frame = 0;
  logic [1:0]  eopf_sel = 0;
  logic sof_irq, eopf_irq, sof_pin, sof_trig;
  logic [10:0] frame_num;

  int errors = 0, checks = 0;
  bit checking = 0, done = 0;

  int m_el = FRAME, m_pulse = 0, m_sel = 0;
  bit m_sirq = 0, m_eirq = 0;
  int m_fn = 0;

  always #(PERIOD/2) clk = ~clk;

  sof_frame_tracker #(.FRAME_CLKS(FRAME), .PULSE_W(PW), .FN_W(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .pin_en(pin_en), .trig_en(trig_en), .eopf_sel(eopf_sel),
    .clr_sof_irq(clr_sof_irq), .clr_eopf_irq(clr_eopf_irq),
    .sof_irq(sof_irq), .eopf_irq(eopf_irq), .frame_num(frame_num),
    .sof_pin(sof_pin), .sof_trig(sof_trig));

  function automatic int thr_of(int s);
    return FRAME * (80 + 5 * s) / 100;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_el = FRAME; m_pulse = 0; m_sel = 0; m_sirq = 0; m_eirq = 0; m_fn = 0;
    end else begin
      bit hit;
      hit = !sof_stb && (m_el == thr_of(m_sel));
      if (sof_stb) begin
        m_sirq = 1; m_fn = sof_frame; m_pulse = PW; m_el = 0; m_sel = eopf_sel;
      end else begin
        if (clr_sof_irq) m_sirq = 0;
        if (m_pulse > 0) m_pulse--;
        if (m_el < FRAME) m_el++;
      end
      if (hit) m_eirq = 1;
      else if (clr_eopf_irq) m_eirq = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (checking && !done) begin
    chk(sof_irq === m_sirq, "R1 sof_irq", sof_irq, m_sirq);
    chk(frame_num === 11'(m_fn), "R2 frame_num", frame_num, m_fn);
    chk(sof_pin === ((m_pulse > 0) && pin_en), "R3/R4 sof_pin", sof_pin, (m_pulse > 0) && pin_en);
    chk(sof_trig === ((m_pulse > 0) && trig_en), "R4 sof_trig", sof_trig, (m_pulse > 0) && trig_en);
    chk(eopf_irq === m_eirq, "R5/R6/R7/R8 eopf_irq", eopf_irq, m_eirq);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int fn, input int sel);
    sof_frame = 11'(fn); eopf_sel = 2'(sel); sof_stb = 1;
    @(negedge clk); sof_stb = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; checking = 1;
    // R9: reset state, no alert before the first strobe even after a full frame
    idle(FRAME + 20);
    pin_en = 1;
    strobe(5, 0);                   // R5 80%
    idle(FRAME + 30);               // R6 saturation, single alert
    clr_sof_irq = 1; clr_eopf_irq = 1; @(negedge clk);
    clr_sof_irq = 0; clr_eopf_irq = 0;
    trig_en = 1; pin_en = 0;
    strobe(2047, 1);                // R2 max frame number, R5 85%
    idle(5);
    strobe(6, 1);                   // R3 restart during pulse
    eopf_sel = 3; idle(60);         // R8 mid-frame change ignored
    clr_eopf_irq = 1; idle(FRAME); clr_eopf_irq = 0;  // R7 clear races set
    pin_en = 1; trig_en = 1;
    strobe(7, 2);                   // R5 90%
    clr_sof_irq = 1; sof_stb = 1; @(negedge clk); sof_stb = 0; clr_sof_irq = 0; // R1 set wins
    idle(FRAME + 10);
    clr_eopf_irq = 1; @(negedge clk); clr_eopf_irq = 0;
    strobe(100, 3);                 // R5 95%
    idle(FRAME + 10);
    rst_n = 0; @(negedge clk); rst_n = 1; idle(FRAME + 5); // R9 again
    finish_run();
  end

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule